// File: doc/BRIEF.md
# Alert Limit Comparator and Flags

This block watches the results of a measurement engine and raises an alert when a chosen result crosses a programmed threshold. It holds two 16-bit registers: a control/status word and a limit word. The control word selects one of five limit functions: shunt over-limit, shunt under-limit, bus over-limit, bus under-limit and power over-limit. It also sets the alert polarity and chooses between latched and transparent alerting. A further control bit lets the conversion-ready event drive the same alert pin.

Each time the measurement engine pulses `conv_done_i`, the block compares the selected result against the limit and updates two flags. The alert-function flag records a limit violation. The ready flag records that a full conversion has finished. Both flags clear when the control/status word is read through the register port. The ready flag also clears on a configuration write elsewhere in the chip, unless that write selects power-down. The math-overflow and memory-error status bits come from outside the block and are only reflected in the read data.

Top module: `alert_limit_unit`

## Requirements
- R1: After reset, the control/status word and the limit word read 0x0000, and `alert_o` is high (inactive, active-low polarity).
- R2: Bits 15, 14, 13, 12 and 11 of the control/status word enable, from highest to lowest priority: shunt over-limit, shunt under-limit, bus over-limit, bus under-limit and power over-limit. A write keeps only the highest-priority enable bit that is set in the written data.
- R3: A limit is checked only at a `conv_done_i` pulse. Over-limit means the result is strictly greater than the limit, and under-limit means it is strictly less. Shunt results are compared as two's complement values; bus and power results are compared unsigned. With no enable set, no violation is recorded.
- R4: The ready flag (bit 3) is set one cycle after `conv_done_i`. It is cleared by a control/status read or by `cfg_wr_i` with `cfg_pd_i` low. `cfg_wr_i` with `cfg_pd_i` high leaves it unchanged. If a set and a clear fall in the same cycle, the flag stays set.
- R5: In latched mode (bit 0 = 1), the function flag (bit 4) and the alert are set by a violating conversion. They stay set through later non-violating conversions until the control/status word is read.
- R6: In transparent mode (bit 0 = 0), every conversion sets the function flag to that conversion's violation result. A read does not clear the flag in this mode.
- R7: When bit 10 is set, a set ready flag also activates the alert. When bit 10 is clear, the ready flag has no effect on the alert.
- R8: Bit 1 selects the alert polarity. With 0, an active alert drives `alert_o` low. With 1, an active alert drives `alert_o` high.
- R9: Bits 9 to 6 always read as zero. Bit 5 reads `mem_err_i` and bit 2 reads `ovf_i`. None of bits 9 to 2 can be written. The limit word reads back all 16 bits that were written.
- R10: `reg_rdata_o` shows the selected register combinationally in the same cycle as the read strobe. It carries the flag values from before the clear that the read causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register select: 0 control/status, 1 limit |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (read side effects) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| cfg_wr_i | input | 1 | Configuration register write event |
| cfg_pd_i | input | 1 | That configuration write selects power-down |
| conv_done_i | input | 1 | Conversion, averaging and math complete (pulse) |
| shunt_i | input | 16 | Shunt result, two's complement |
| bus_i | input | 16 | Bus result, unsigned |
| power_i | input | 16 | Power result, unsigned |
| ovf_i | input | 1 | Math overflow status |
| mem_err_i | input | 1 | Memory error status |
| alert_o | output | 1 | Alert output, polarity per bit 1 |

## Verification
The bench places results on both sides of each limit, including the equal value. A comparator that used greater-or-equal, or that compared power signed (0x8000 against 0x7000), would raise a false alert or miss one. It writes several enable bits at once, which exposes a design that keeps a lower-priority function. It also drives changing results with no done pulse, which exposes a comparator that is not gated by the pulse. It holds a latched alert across a non-violating conversion and reads repeatedly in transparent mode, which separates the two clearing rules. It also sends a done pulse and a read in the same cycle; if the clear won, the ready flag and the routed alert would be lost.

// File: rtl/alert_limit_pkg.sv
package alert_limit_pkg;
  localparam int DW    = 16;
  localparam int NFUNC = 5;

  // control/status bit positions
  localparam int EN_HI   = 15;
  localparam int EN_LO   = EN_HI - NFUNC + 1;
  localparam int CNV_BIT = 10;
  localparam int MEM_BIT = 5;
  localparam int AFF_BIT = 4;
  localparam int RDY_BIT = 3;
  localparam int OVF_BIT = 2;
  localparam int POL_BIT = 1;
  localparam int LAT_BIT = 0;

  typedef enum logic [1:0] {SRC_SHUNT = 2'd0, SRC_BUS = 2'd1, SRC_POWER = 2'd2} src_e;

  // function index 0 is highest priority (bit EN_HI)
  function automatic src_e fn_src(input int idx);
    if (idx < 2)      return SRC_SHUNT;
    else if (idx < 4) return SRC_BUS;
    else              return SRC_POWER;
  endfunction

  function automatic bit fn_signed(input int idx);
    return idx < 2;
  endfunction

  function automatic bit fn_over(input int idx);
    return (idx % 2) == 0;
  endfunction
endpackage

// File: rtl/alu_en_filter.sv
module alu_en_filter #(
  parameter int NF = 5
) (
  input  logic [NF-1:0] req_i,
  output logic [NF-1:0] keep_o
);
  // index 0 has highest priority
  for (genvar i = 0; i < NF; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign keep_o[i] = req_i[i];
    end else begin : g_low
      assign keep_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end
endmodule

// File: rtl/alu_limit_cmp.sv
module alu_limit_cmp
  import alert_limit_pkg::*;
#(
  parameter int W  = 16,
  parameter int NF = 5
) (
  input  logic [W-1:0]  shunt_i,
  input  logic [W-1:0]  bus_i,
  input  logic [W-1:0]  power_i,
  input  logic [W-1:0]  limit_i,
  input  logic [NF-1:0] en_i,
  output logic          hit_o
);
  logic [NF-1:0] viol;

  for (genvar i = 0; i < NF; i++) begin : g_fn
    logic [W-1:0] src;
    if (fn_src(i) == SRC_SHUNT) begin : g_sh
      assign src = shunt_i;
    end else if (fn_src(i) == SRC_BUS) begin : g_bus
      assign src = bus_i;
    end else begin : g_pwr
      assign src = power_i;
    end

    if (fn_signed(i)) begin : g_s
      if (fn_over(i)) begin : g_ov
        assign viol[i] = $signed(src) > $signed(limit_i);
      end else begin : g_un
        assign viol[i] = $signed(src) < $signed(limit_i);
      end
    end else begin : g_u
      if (fn_over(i)) begin : g_ov
        assign viol[i] = src > limit_i;
      end else begin : g_un
        assign viol[i] = src < limit_i;
      end
    end
  end

  assign hit_o = |(viol & en_i);
endmodule

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_done_i,
  input  logic hit_i,
  input  logic lat_i,
  input  logic rd_clr_i,
  input  logic cfg_clr_i,
  output logic rdy_o,
  output logic aff_o
);
  logic rdy_q, rdy_d, aff_q, aff_d;

  always_comb begin
    rdy_d = rdy_q;
    if (conv_done_i)                 rdy_d = 1'b1;
    else if (rd_clr_i || cfg_clr_i)  rdy_d = 1'b0;
  end

  always_comb begin
    aff_d = aff_q;
    if (lat_i) begin
      if (rd_clr_i) aff_d = 1'b0;
      if (conv_done_i && hit_i) aff_d = 1'b1;
    end else if (conv_done_i) begin
      aff_d = hit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      aff_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      aff_q <= aff_d;
    end
  end

  assign rdy_o = rdy_q;
  assign aff_o = aff_q;

  // R4
  rdy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> rdy_q);
  // R4
  rdy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_done_i && (rd_clr_i || cfg_clr_i)) |=> !rdy_q);
  // R5
  lat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_i && aff_q && !rd_clr_i) |=> aff_q);
  // R6
  trans_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lat_i && conv_done_i && !hit_i) |=> !aff_q);
endmodule

// File: rtl/alert_limit_unit.sv
module alert_limit_unit
  import alert_limit_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_sel_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          cfg_wr_i,
  input  logic          cfg_pd_i,
  input  logic          conv_done_i,
  input  logic [DW-1:0] shunt_i,
  input  logic [DW-1:0] bus_i,
  input  logic [DW-1:0] power_i,
  input  logic          ovf_i,
  input  logic          mem_err_i,
  output logic          alert_o
);
  logic [NFUNC-1:0] en_q, en_req, en_keep;
  logic             cnv_q, pol_q, lat_q;
  logic [DW-1:0]    limit_q;
  logic             wr_mask, wr_lim, rd_mask;
  logic             hit, rdy, aff, act;
  logic [DW-1:0]    mask_word;
  logic             unused_wdata;

  assign wr_mask = reg_wr_i & ~reg_sel_i;
  assign wr_lim  = reg_wr_i &  reg_sel_i;
  assign rd_mask = reg_rd_i & ~reg_sel_i;
  assign unused_wdata = ^reg_wdata_i[CNV_BIT-1:OVF_BIT];

  always_comb begin
    for (int i = 0; i < NFUNC; i++) en_req[i] = reg_wdata_i[EN_HI-i];
  end

  alu_en_filter #(.NF(NFUNC)) u_filter (
    .req_i  (en_req),
    .keep_o (en_keep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      cnv_q   <= 1'b0;
      pol_q   <= 1'b0;
      lat_q   <= 1'b0;
      limit_q <= '0;
    end else begin
      if (wr_mask) begin
        en_q  <= en_keep;
        cnv_q <= reg_wdata_i[CNV_BIT];
        pol_q <= reg_wdata_i[POL_BIT];
        lat_q <= reg_wdata_i[LAT_BIT];
      end
      if (wr_lim) limit_q <= reg_wdata_i;
    end
  end

  alu_limit_cmp #(.W(DW), .NF(NFUNC)) u_cmp (
    .shunt_i (shunt_i),
    .bus_i   (bus_i),
    .power_i (power_i),
    .limit_i (limit_q),
    .en_i    (en_q),
    .hit_o   (hit)
  );

  alu_flag_ctrl u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_done_i (conv_done_i),
    .hit_i       (hit),
    .lat_i       (lat_q),
    .rd_clr_i    (rd_mask),
    .cfg_clr_i   (cfg_wr_i & ~cfg_pd_i),
    .rdy_o       (rdy),
    .aff_o       (aff)
  );

  always_comb begin
    mask_word = '0;
    for (int i = 0; i < NFUNC; i++) mask_word[EN_HI-i] = en_q[i];
    mask_word[CNV_BIT] = cnv_q;
    mask_word[MEM_BIT] = mem_err_i;
    mask_word[AFF_BIT] = aff;
    mask_word[RDY_BIT] = rdy;
    mask_word[OVF_BIT] = ovf_i;
    mask_word[POL_BIT] = pol_q;
    mask_word[LAT_BIT] = lat_q;
  end

  assign reg_rdata_o = reg_sel_i ? limit_q : mask_word;

  assign act     = aff | (cnv_q & rdy);
  assign alert_o = pol_q ? act : ~act;

  // R2
  en_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_q));
  // R2
  en_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask && (|reg_wdata_i[EN_HI:EN_LO])) |=> (en_q != '0));
  // R9
  lim_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lim |=> (limit_q == $past(reg_wdata_i)));
endmodule

// File: tb/alert_limit_unit_tb.sv
module alert_limit_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        cfg_wr = 1'b0, cfg_pd = 1'b0, done = 1'b0;
  logic [15:0] shunt = '0, bus = '0, power = '0;
  logic        ovf = 1'b0, mem_err = 1'b0, alert;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  alert_limit_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(reg_sel), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cfg_wr_i(cfg_wr), .cfg_pd_i(cfg_pd), .conv_done_i(done),
    .shunt_i(shunt), .bus_i(bus), .power_i(power), .ovf_i(ovf),
    .mem_err_i(mem_err), .alert_o(alert)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_alert(input string req, input logic exp);
    #1 check(req, {15'b0, alert}, {15'b0, exp});
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] d);
    @(negedge clk); reg_sel = sel; wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [15:0] d);
    @(negedge clk); reg_sel = sel; reg_rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic conv(input logic [15:0] s, input logic [15:0] b, input logic [15:0] p);
    @(negedge clk); shunt = s; bus = b; power = p; done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic cfg(input logic pd);
    @(negedge clk); cfg_pd = pd; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; cfg_pd = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk_alert("R1 alert idle", 1'b1);
    rd_reg(1'b0, d); check("R1 mask reset", d, 16'h0000);
    rd_reg(1'b1, d); check("R1 limit reset", d, 16'h0000);
  endtask

  task automatic t_fields;
    logic [15:0] d;
    wr_reg(1'b0, 16'hF800); rd_reg(1'b0, d); check("R2 keep shunt over", d, 16'h8000);
    wr_reg(1'b0, 16'h1800); rd_reg(1'b0, d); check("R2 keep bus under", d, 16'h1000);
    wr_reg(1'b0, 16'h0800); rd_reg(1'b0, d); check("R2 power only", d, 16'h0800);
    wr_reg(1'b0, 16'h03FC); rd_reg(1'b0, d); check("R9 reserved/status unwritable", d, 16'h0000);
    ovf = 1'b1; mem_err = 1'b1;
    rd_reg(1'b0, d); check("R9 status inputs", d, 16'h0024);
    ovf = 1'b0; mem_err = 1'b0;
    wr_reg(1'b1, 16'hBEEF); rd_reg(1'b1, d); check("R9 limit readback", d, 16'hBEEF);
  endtask

  task automatic t_shunt_over_latched;
    logic [15:0] d;
    wr_reg(1'b0, 16'h8001); wr_reg(1'b1, 16'hFF00);
    conv(16'hFF00, 16'h0, 16'h0); chk_alert("R3 shunt equal no alert", 1'b1);
    conv(16'h0001, 16'h0, 16'h0); chk_alert("R3 shunt signed over", 1'b0);
    rd_reg(1'b0, d); check("R10 read shows pre-clear flags", d, 16'h8019);
    chk_alert("R5 read clears latched alert", 1'b1);
    rd_reg(1'b0, d); check("R5 flags cleared by read", d, 16'h8001);
  endtask

  task automatic t_shunt_under_transparent;
    logic [15:0] d;
    wr_reg(1'b0, 16'h4000); wr_reg(1'b1, 16'h0000);
    conv(16'h8000, 16'h0, 16'h0); chk_alert("R3 shunt signed under", 1'b0);
    rd_reg(1'b0, d); check("R6 first read", d, 16'h4018);
    rd_reg(1'b0, d); check("R6 read keeps flag", d, 16'h4010);
    chk_alert("R6 alert held after read", 1'b0);
    conv(16'h0000, 16'h0, 16'h0); chk_alert("R6 clean conversion clears", 1'b1);
    rd_reg(1'b0, d); check("R7 ready set but not routed", d, 16'h4008);
  endtask

  task automatic t_bus_power;
    logic [15:0] d;
    wr_reg(1'b0, 16'h2000); wr_reg(1'b1, 16'h4000);
    conv(16'h7FFF, 16'h7FFF, 16'h0); chk_alert("R3 bus over", 1'b0);
    conv(16'h7FFF, 16'h4000, 16'h0); chk_alert("R3 bus equal", 1'b1);
    wr_reg(1'b0, 16'h1000); wr_reg(1'b1, 16'h0100);
    conv(16'h0, 16'h00FF, 16'h0); chk_alert("R3 bus under", 1'b0);
    conv(16'h0, 16'h0100, 16'h0); chk_alert("R3 bus under equal", 1'b1);
    wr_reg(1'b0, 16'h0800); wr_reg(1'b1, 16'h7000);
    conv(16'h0, 16'h0, 16'h8000); chk_alert("R3 power unsigned over", 1'b0);
    conv(16'h0, 16'h0, 16'h7000); chk_alert("R3 power equal", 1'b1);
    rd_reg(1'b0, d);
  endtask

  task automatic t_latched_hold;
    logic [15:0] d;
    wr_reg(1'b0, 16'h0801); wr_reg(1'b1, 16'h0010);
    conv(16'h0, 16'h0, 16'h0020); chk_alert("R5 latched set", 1'b0);
    conv(16'h0, 16'h0, 16'h0005); chk_alert("R5 held over clean conv", 1'b0);
    rd_reg(1'b0, d); check("R5 read value", d, 16'h0819);
    chk_alert("R5 released", 1'b1);
  endtask

  task automatic t_no_enable_and_gating;
    logic [15:0] d;
    wr_reg(1'b0, 16'h0000); wr_reg(1'b1, 16'h0000);
    conv(16'h7FFF, 16'h7FFF, 16'hFFFF);
    rd_reg(1'b0, d); check("R3 no enable no flag", d, 16'h0008);
    wr_reg(1'b0, 16'h8000);
    @(negedge clk); shunt = 16'h0005; bus = 16'h0; power = 16'h0;
    repeat (3) @(negedge clk);
    chk_alert("R3 no pulse no compare", 1'b1);
    conv(16'h0005, 16'h0, 16'h0); chk_alert("R3 pulse compares", 1'b0);
    conv(16'h0000, 16'h0, 16'h0);
    rd_reg(1'b0, d);
  endtask

  task automatic t_ready;
    logic [15:0] d;
    wr_reg(1'b0, 16'h0400);
    chk_alert("R7 idle", 1'b1);
    conv(16'h0, 16'h0, 16'h0); chk_alert("R7 ready routed", 1'b0);
    cfg(1'b1); chk_alert("R4 power-down write keeps ready", 1'b0);
    cfg(1'b0); chk_alert("R4 config write clears ready", 1'b1);
    conv(16'h0, 16'h0, 16'h0); chk_alert("R7 ready again", 1'b0);
    rd_reg(1'b0, d); chk_alert("R4 read clears ready", 1'b1);
    @(negedge clk); reg_sel = 1'b0; reg_rd = 1'b1; done = 1'b1;
    @(negedge clk); reg_rd = 1'b0; done = 1'b0;
    chk_alert("R4 set wins over read", 1'b0);
    rd_reg(1'b0, d); check("R4 ready kept", d, 16'h0408);
  endtask

  task automatic t_polarity;
    logic [15:0] d;
    wr_reg(1'b0, 16'h0402); chk_alert("R8 high polarity idle", 1'b0);
    conv(16'h0, 16'h0, 16'h0); chk_alert("R8 high polarity active", 1'b1);
    rd_reg(1'b0, d); chk_alert("R8 back to idle", 1'b0);
    wr_reg(1'b0, 16'h4002); wr_reg(1'b1, 16'h0000);
    conv(16'hFFFF, 16'h0, 16'h0); chk_alert("R8 limit alert high", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_shunt_over_latched();
    t_shunt_under_transparent();
    t_bus_power();
    t_latched_hold();
    t_no_enable_and_gating();
    t_ready();
    t_polarity();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule